// File: doc/BRIEF.md
# ACPI Power Management Timer

This block is a free-running counter that gives software a steady, monotonic time base. It runs from a 14.31818 MHz reference clock. A prescaler divides that clock by four, so the 24-bit count advances at 3.579545 MHz. Software reads the count through a one-bit-strobe read port and gets a 32-bit word in which the unused upper bits are zero. Each time bit 22 of the count falls from 1 to 0, which happens about every 2.34 seconds at the nominal rate, a sticky overflow status flag is set. When software has also set the enable bit, a level-sensitive system control interrupt is raised.

The count only moves while the system is in the fully working state. A small run-control state machine tracks that state. It has two states. `RS_HALT` freezes both the prescaler and the count, and it is the state after reset. `RS_RUN` lets the prescaler advance. There are two transitions. *wake* goes from `RS_HALT` to `RS_RUN` when `in_working` is sampled high. *doze* goes from `RS_RUN` to `RS_HALT` when `in_working` is sampled low. Leaving the working state therefore freezes the count and the prescaler phase, and both resume exactly where they stopped. Only the platform reset clears the count.

The count width, the watched bit, the prescale ratio and the read width are parameters. Their defaults are 24, 22, 4 and 32.

Top module: `pwr_timer_top`

## Requirements
- R1: A read strobe `rd_en` sampled at a clock edge returns, on the following cycle, `rd_valid` high for one cycle. `rd_data` then carries the count as it stood at that edge in bits CNT_W-1:0, with every bit above CNT_W-1 reading zero. All count bits come from the same cycle.
- R2: While `rst_plat_n` is low at a clock edge, the count, the prescaler, the status flag, the enable bit, `rd_valid`, `rd_data` and `sci_o` are all cleared, and the run-control state becomes `RS_HALT`.
- R3: In `RS_RUN` the count increases by exactly one on every fourth clock edge, and never by more than one.
- R4: The run-control state takes the value of `in_working` sampled at the previous edge (1 = `RS_RUN`). In `RS_HALT` neither the count nor the prescaler phase changes. On return to `RS_RUN` counting resumes from the held value and phase, without clearing.
- R5: One clock edge after count bit EDGE_BIT changes from 1 to 0, `ovf_sts` becomes 1. This includes the change caused by the count wrapping.
- R6: A write with `csr_addr` = 0 and `csr_wdata` = 1 clears `ovf_sts`. A write with `csr_addr` = 0 and `csr_wdata` = 0 leaves it unchanged. Otherwise `ovf_sts` holds its value.
- R7: If a set event from R5 and a clearing write from R6 fall on the same edge, `ovf_sts` ends up 1.
- R8: A write with `csr_addr` = 1 loads `csr_wdata` into `ovf_en`. `sci_o` is high exactly while both `ovf_sts` and `ovf_en` are 1.
- R9: From all ones, the next increment takes the count to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | 14.31818 MHz reference clock |
| rst_plat_n | input | 1 | Platform reset, active low, synchronous |
| in_working | input | 1 | 1 while the system is in the fully working state |
| rd_en | input | 1 | Read strobe for the timer word |
| rd_data | output | RD_W | Captured timer word, upper bits zero |
| rd_valid | output | 1 | Marks `rd_data` as the answer to the previous strobe |
| csr_wr | input | 1 | Control write strobe |
| csr_addr | input | 1 | Write target: 0 = status, 1 = enable |
| csr_wdata | input | 1 | Write data bit |
| ovf_sts | output | 1 | Sticky overflow status flag |
| ovf_en | output | 1 | Overflow interrupt enable bit |
| sci_o | output | 1 | Level system control interrupt |

## Verification
At full width, bit 22 first falls only after 2^23 increments, which is more than 33 million clock cycles. A port-driven run cannot reach that, so the bench builds the timer with an 8-bit count watching bit 6. That exercises the same falling-edge logic every 512 cycles, including the fall produced by a wrap. The hardest case is a clearing write that lands on the very edge where the status is being set. The bench keeps a cycle-exact model of the prescaler phase and of the previous watched bit, and times the write so that both arrive on that same edge.

// File: rtl/pmt_pkg.sv
package pmt_pkg;

    // Run-control states; RS_HALT is the reset state.
    typedef enum logic {
        RS_HALT = 1'b0,
        RS_RUN  = 1'b1
    } run_state_e;

    // Control write targets (bench and software depend on these codes).
    localparam logic ADDR_STS = 1'b0;
    localparam logic ADDR_EN  = 1'b1;

endpackage

// File: rtl/pmt_run_ctl.sv
module pmt_run_ctl
    import pmt_pkg::*;
#(
    parameter int unsigned PRE_DIV = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       in_working,
    output run_state_e state_o,
    output logic       tick_o
);

    localparam int unsigned    PRE_W    = (PRE_DIV > 1) ? $clog2(PRE_DIV) : 1;
    localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(PRE_DIV - 1);

    run_state_e       state_q;
    run_state_e       state_d;
    logic             run_en;
    logic [PRE_W-1:0] pre_q;

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= RS_HALT;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions: wake (HALT -> RUN), doze (RUN -> HALT).
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RS_HALT: if (in_working)  state_d = RS_RUN;
            RS_RUN:  if (!in_working) state_d = RS_HALT;
            default: state_d = RS_HALT;
        endcase
    end

    // State outputs.
    always_comb begin
        run_en = 1'b0;
        unique case (state_q)
            RS_HALT: run_en = 1'b0;
            RS_RUN:  run_en = 1'b1;
            default: run_en = 1'b0;
        endcase
    end

    // Prescaler: advances only while running, so its phase survives a halt.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_q <= '0;
        end else if (run_en) begin
            pre_q <= (pre_q == PRE_LAST) ? '0 : pre_q + 1'b1;
        end
    end

    assign tick_o  = run_en && (pre_q == PRE_LAST);
    assign state_o = state_q;

endmodule

// File: rtl/pmt_counter.sv
module pmt_counter #(
    parameter int unsigned CNT_W    = 24,
    parameter int unsigned EDGE_BIT = 22
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             fall_o
);

    logic [CNT_W-1:0] cnt_q;
    logic             prev_q;

    // Count register, cleared only by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (tick_i) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Registered copy of the watched bit for a clean falling-edge pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= 1'b0;
        end else begin
            prev_q <= cnt_q[EDGE_BIT];
        end
    end

    assign fall_o = prev_q & ~cnt_q[EDGE_BIT];
    assign cnt_o  = cnt_q;

endmodule

// File: rtl/pmt_csr.sv
module pmt_csr
    import pmt_pkg::*;
#(
    parameter int unsigned CNT_W = 24,
    parameter int unsigned RD_W  = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fall_i,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic             csr_wr,
    input  logic             csr_addr,
    input  logic             csr_wdata,
    input  logic             rd_en,
    output logic [RD_W-1:0]  rd_data,
    output logic             rd_valid,
    output logic             sts_o,
    output logic             en_o,
    output logic             sci_o
);

    logic            sts_q;
    logic            en_q;
    logic            clr_hit;
    logic            en_hit;
    logic [RD_W-1:0] rd_word;
    logic [RD_W-1:0] rd_q;
    logic            rv_q;

    assign clr_hit = csr_wr && (csr_addr == ADDR_STS) && csr_wdata;
    assign en_hit  = csr_wr && (csr_addr == ADDR_EN);

    // Sticky status: a set event outranks a clearing write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sts_q <= 1'b0;
        end else if (fall_i) begin
            sts_q <= 1'b1;
        end else if (clr_hit) begin
            sts_q <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q <= 1'b0;
        end else if (en_hit) begin
            en_q <= csr_wdata;
        end
    end

    // Read word: zero-extend the count when it is narrower than the port.
    generate
        if (CNT_W < RD_W) begin : g_pad
            assign rd_word = {{(RD_W - CNT_W){1'b0}}, cnt_i};
        end else begin : g_trim
            assign rd_word = cnt_i[RD_W-1:0];
        end
    endgenerate

    // Single-cycle capture keeps every bit of a read coherent.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q <= '0;
            rv_q <= 1'b0;
        end else begin
            rv_q <= rd_en;
            if (rd_en) begin
                rd_q <= rd_word;
            end
        end
    end

    assign rd_data  = rd_q;
    assign rd_valid = rv_q;
    assign sts_o    = sts_q;
    assign en_o     = en_q;
    assign sci_o    = sts_q & en_q;

endmodule

// File: rtl/pwr_timer_top.sv
module pwr_timer_top
    import pmt_pkg::*;
#(
    parameter int unsigned CNT_W    = 24,
    parameter int unsigned EDGE_BIT = 22,
    parameter int unsigned PRE_DIV  = 4,
    parameter int unsigned RD_W     = 32
) (
    input  logic            clk_ref,
    input  logic            rst_plat_n,
    input  logic            in_working,
    input  logic            rd_en,
    output logic [RD_W-1:0] rd_data,
    output logic            rd_valid,
    input  logic            csr_wr,
    input  logic            csr_addr,
    input  logic            csr_wdata,
    output logic            ovf_sts,
    output logic            ovf_en,
    output logic            sci_o
);

    run_state_e       run_state;
    logic             run_active;
    logic             pre_tick;
    logic [CNT_W-1:0] count;
    logic             bit_fall;

    pmt_run_ctl #(
        .PRE_DIV (PRE_DIV)
    ) u_run (
        .clk        (clk_ref),
        .rst_n      (rst_plat_n),
        .in_working (in_working),
        .state_o    (run_state),
        .tick_o     (pre_tick)
    );

    assign run_active = (run_state == RS_RUN);

    pmt_counter #(
        .CNT_W    (CNT_W),
        .EDGE_BIT (EDGE_BIT)
    ) u_cnt (
        .clk    (clk_ref),
        .rst_n  (rst_plat_n),
        .tick_i (pre_tick),
        .cnt_o  (count),
        .fall_o (bit_fall)
    );

    pmt_csr #(
        .CNT_W (CNT_W),
        .RD_W  (RD_W)
    ) u_csr (
        .clk       (clk_ref),
        .rst_n     (rst_plat_n),
        .fall_i    (bit_fall),
        .cnt_i     (count),
        .csr_wr    (csr_wr),
        .csr_addr  (csr_addr),
        .csr_wdata (csr_wdata),
        .rd_en     (rd_en),
        .rd_data   (rd_data),
        .rd_valid  (rd_valid),
        .sts_o     (ovf_sts),
        .en_o      (ovf_en),
        .sci_o     (sci_o)
    );

endmodule

// File: rtl/pmt_checker.sv
module pmt_checker #(
    parameter int unsigned CNT_W    = 24,
    parameter int unsigned EDGE_BIT = 22,
    parameter int unsigned RD_W     = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             run,
    input logic             tick,
    input logic [CNT_W-1:0] cnt,
    input logic             sts,
    input logic             csr_wr,
    input logic             csr_addr,
    input logic             csr_wdata,
    input logic             rd_valid,
    input logic [RD_W-1:0]  rd_data
);

    AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> ((rd_data >> CNT_W) == {RD_W{1'b0}})); // R1

    AST_HALT_FREEZES: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> $stable(cnt)); // R4

    AST_STEP_BY_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt != $past(cnt)) |-> (cnt == CNT_W'($past(cnt) + 1'b1))); // R3

    AST_TICK_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick); // R3

    AST_FALL_SETS_STS: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cnt[EDGE_BIT]) |=> sts); // R5

    AST_STS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (sts && !(csr_wr && (csr_addr == 1'b0) && csr_wdata)) |=> sts); // R6

endmodule

bind pwr_timer_top pmt_checker #(
    .CNT_W    (CNT_W),
    .EDGE_BIT (EDGE_BIT),
    .RD_W     (RD_W)
) u_pmt_chk (
    .clk       (clk_ref),
    .rst_n     (rst_plat_n),
    .run       (run_active),
    .tick      (pre_tick),
    .cnt       (count),
    .sts       (ovf_sts),
    .csr_wr    (csr_wr),
    .csr_addr  (csr_addr),
    .csr_wdata (csr_wdata),
    .rd_valid  (rd_valid),
    .rd_data   (rd_data)
);

// File: tb/pwr_timer_top_bench.sv
module pwr_timer_top_bench;

    localparam int unsigned CW = 8;
    localparam int unsigned EB = 6;
    localparam int unsigned RW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_working = 1'b0;
    logic          rd_en = 1'b0;
    logic [RW-1:0] rd_data;
    logic          rd_valid;
    logic          csr_wr = 1'b0;
    logic          csr_addr = 1'b0;
    logic          csr_wdata = 1'b0;
    logic          ovf_sts;
    logic          ovf_en;
    logic          sci;

    int n_cmp = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    pwr_timer_top #(
        .CNT_W    (CW),
        .EDGE_BIT (EB),
        .PRE_DIV  (4),
        .RD_W     (RW)
    ) u_pwr_timer_top (
        .clk_ref    (clk),
        .rst_plat_n (rst_n),
        .in_working (in_working),
        .rd_en      (rd_en),
        .rd_data    (rd_data),
        .rd_valid   (rd_valid),
        .csr_wr     (csr_wr),
        .csr_addr   (csr_addr),
        .csr_wdata  (csr_wdata),
        .ovf_sts    (ovf_sts),
        .ovf_en     (ovf_en),
        .sci_o      (sci)
    );

    // Cycle model built from the requirements.
    bit          m_run = 1'b0;
    int          m_pre = 0;
    logic [CW-1:0] m_cnt = '0;
    bit          m_prev = 1'b0;
    bit          m_sts = 1'b0;
    bit          m_en = 1'b0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_run = 1'b0; m_pre = 0; m_cnt = '0;
            m_prev = 1'b0; m_sts = 1'b0; m_en = 1'b0;
        end else begin
            bit tk;
            bit ev;
            bit oldbit;
            tk = m_run && (m_pre == 3);                 // R3
            ev = m_prev && !m_cnt[EB];                  // R5
            oldbit = m_cnt[EB];
            if (m_run) m_pre = (m_pre + 1) % 4;          // R4
            if (tk) m_cnt = m_cnt + 1'b1;                // R9 wraps naturally
            m_prev = oldbit;
            if (ev) m_sts = 1'b1;                        // R7
            else if (csr_wr && !csr_addr && csr_wdata) m_sts = 1'b0; // R6
            if (csr_wr && csr_addr) m_en = csr_wdata;    // R8
            m_run = in_working;                          // R4
        end
    end

    task automatic check(string tag, logic [RW-1:0] act, logic [RW-1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Scoreboard queues.
    logic [RW-1:0] exp_q[$];
    string         tag_q[$];

    // Driver: call at a negedge.
    task automatic do_read(string tag);
        rd_en = 1'b1;
        exp_q.push_back(RW'(m_cnt));
        tag_q.push_back(tag);
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    // Monitor.
    always @(negedge clk) begin
        if (rst_n) begin
            check("R5 R6 R7 status", {31'b0, ovf_sts}, {31'b0, m_sts});
            check("R8 enable", {31'b0, ovf_en}, {31'b0, m_en});
            check("R8 sci", {31'b0, sci}, {31'b0, m_sts & m_en});
            if (rd_valid) begin
                if (exp_q.size() == 0) begin
                    check("R1 unexpected read", rd_data, '1);
                end else begin
                    logic [RW-1:0] e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    check(t, rd_data, e);
                end
            end
        end
    end

    task automatic csr_write(logic a, logic d);
        csr_wr = 1'b1; csr_addr = a; csr_wdata = d;
        @(negedge clk);
        csr_wr = 1'b0; csr_wdata = 1'b0;
    endtask

    task automatic wait_cnt(logic [CW-1:0] v);
        do @(negedge clk); while (m_cnt != v);
    endtask

    task automatic wait_set_edge();
        do @(negedge clk); while (!(m_prev && !m_cnt[EB]));
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        // R2: reset state.
        repeat (3) @(negedge clk);
        check("R2 rd_valid", {31'b0, rd_valid}, 32'd0);
        check("R2 rd_data", rd_data, 32'd0);
        check("R2 status", {31'b0, ovf_sts}, 32'd0);
        check("R2 enable", {31'b0, ovf_en}, 32'd0);
        check("R2 sci", {31'b0, sci}, 32'd0);
        rst_n = 1'b1;

        // R4: halted from the start.
        repeat (20) @(negedge clk);
        do_read("R4 halted after reset");

        // R3 / R1: running, back-to-back and spaced reads.
        in_working = 1'b1;
        repeat (13) @(negedge clk);
        do_read("R3 run a");
        do_read("R3 run b");
        do_read("R1 run c");
        repeat (7) @(negedge clk);
        do_read("R3 run d");

        // R4: halt mid-phase, hold, resume.
        in_working = 1'b0;
        repeat (3) @(negedge clk);
        do_read("R4 hold a");
        repeat (25) @(negedge clk);
        do_read("R4 hold b");
        in_working = 1'b1;
        repeat (6) @(negedge clk);
        do_read("R4 resume");

        // R5: first fall, enable off.
        wait_set_edge();
        @(negedge clk);
        check("R5 status set", {31'b0, ovf_sts}, 32'd1);
        check("R8 sci masked", {31'b0, sci}, 32'd0);

        // R6: writing 0 keeps, writing 1 clears.
        csr_write(1'b0, 1'b0);
        check("R6 write zero keeps", {31'b0, ovf_sts}, 32'd1);
        csr_write(1'b0, 1'b1);
        check("R6 write one clears", {31'b0, ovf_sts}, 32'd0);

        // R8 and R9: enable, then the wrap produces the next fall.
        csr_write(1'b1, 1'b1);
        wait_cnt({CW{1'b1}});
        do_read("R9 before wrap");
        wait_cnt('0);
        do_read("R9 after wrap");
        repeat (3) @(negedge clk);
        check("R8 sci high", {31'b0, sci}, 32'd1);
        csr_write(1'b1, 1'b0);
        check("R8 sci drops on enable 0", {31'b0, sci}, 32'd0);
        check("R8 status kept", {31'b0, ovf_sts}, 32'd1);
        csr_write(1'b0, 1'b1);
        csr_write(1'b1, 1'b1);

        // R7: clear on the set edge.
        wait_set_edge();
        csr_wr = 1'b1; csr_addr = 1'b0; csr_wdata = 1'b1;
        @(negedge clk);
        csr_wr = 1'b0; csr_wdata = 1'b0;
        check("R7 set beats clear", {31'b0, ovf_sts}, 32'd1);
        check("R7 sci", {31'b0, sci}, 32'd1);

        // R2: reset mid-run.
        repeat (4) @(negedge clk);
        rst_n = 1'b0;
        in_working = 1'b0;
        repeat (2) @(negedge clk);
        check("R2 mid-run status", {31'b0, ovf_sts}, 32'd0);
        check("R2 mid-run enable", {31'b0, ovf_en}, 32'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        do_read("R2 count cleared");
        repeat (3) @(negedge clk);
        if (exp_q.size() != 0) check("R1 missing read", 32'd0, RW'(exp_q.size()));

        summary();
        $finish;
    end

endmodule